// File: doc/BRIEF.md
# Recovered Reference Clock Edge Generator

This block produces one reference clock pin that feeds an external PLL. On its own it toggles the pin on a free-running schedule taken from a shared 32-bit time counter. Each toggle is one fixed increment after the previous one. When software selects one of two external digital audio receivers and that receiver is judged healthy, the block counts sample events from it. It then places each toggle at the time of the sample that completes a programmed count, so the PLL locks to the incoming stream rather than to the local timer.

Two external sources are supported. Source A delivers a one-cycle strobe per stereo sample pair. Source B is an eight-channel optical stream that marks frame starts and individual audio words; the block derives its sample events from the in-frame channel position. A detection tick, offset by half an increment from the local schedule, closes a measurement window for each source. A source is declared valid when the number of events it delivered in that window lies inside a programmable range.

The edge scheduler is a three-state machine. `ST_INIT` is the single cycle after reset; it captures the time counter and arms the deadlines, and always moves to `ST_FREE`. In `ST_FREE` only the local deadline makes edges. It moves to `ST_TRACK` when the mode selects an external source whose valid flag is set. In `ST_TRACK` sample-count edges are allowed and the local deadline still stands as a fallback. It returns to `ST_FREE` as soon as the mode becomes internal or the selected source loses its valid flag.

Top module: `refclk_edge_gen`

## Requirements
- R1: While reset is asserted, `ref_clk`, `det_tick` and `src_valid` are all 0.
- R2: With `mode_sel` = 0 (internal; code 3 behaves the same), `ref_clk` toggles exactly every `INCR` time units, and strobes on `a_smp`, `b_sync` and `b_word` have no effect on that spacing.
- R3: `det_tick` is a one-cycle pulse. It first fires `INCR/2` time units after a local edge, and then every `INCR` units until the next local edge re-arms it at that edge plus `INCR/2`.
- R4: At each detection tick, each source's `src_valid` bit (bit 0 = source A, bit 1 = source B) becomes 1 if the source delivered between `VMIN` and `VMAX` events inclusive since the previous tick, and 0 otherwise. The count then restarts. `src_valid` changes only in the cycle after a tick.
- R5: With `mode_sel` = 1 and source A valid, `ref_clk` toggles at the sample that completes `SPT_A` samples since the last edge, so a steady stream with period P gives an edge spacing of `SPT_A`·P whenever that exceeds `INCR-MARGIN`.
- R6: A sample-count edge is taken only when its time is strictly later than the last edge plus `INCR-MARGIN`. Otherwise the count is held and each later sample retries, so the spacing between any two edges is always greater than `INCR-MARGIN`.
- R7: After an external edge, the local deadline is set `INCR+MARGIN` later. If the stream stops, the next edge comes that far after the last external edge, and later edges follow every `INCR`.
- R8: With `mode_sel` = 2, source B yields one sample event when its in-frame word index reaches 4 and another when it reaches 8. `b_sync` restarts the index at 0, so a frame of one sync plus eight words gives two events.
- R9: When the selected external source is not valid, edges follow the local schedule every `INCR`.
- R10: All time comparisons use the signed 32-bit difference, so the local schedule spacing is unaffected when the time counter wraps through zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 32 | Free-running time counter, wraps modulo 2^32 |
| mode_sel | input | 2 | 0 internal, 1 source A, 2 source B, 3 internal |
| a_smp | input | 1 | Source A sample-pair strobe |
| b_sync | input | 1 | Source B frame-start strobe |
| b_word | input | 1 | Source B audio word strobe |
| ref_clk | output | 1 | Reference clock toward the PLL |
| det_tick | output | 1 | One-cycle detection window strobe |
| src_valid | output | 2 | Per-source validity, bit 0 A, bit 1 B |

## Verification
The bench builds the block with `INCR`=40, `MARGIN`=8, `SPT_A`=5, `SPT_B`=4, `VMIN`=3 and `VMAX`=8, and starts the time counter 256 units below wrap. These short values let a few hundred cycles cover many edges and cross the zero boundary. They also separate the cases by spacing: stream period 7 gives 35-unit edges, period 5 gives 35 only through margin rejection (25 without it), source B gives 36, and a stopped stream gives 48 and then 40. Stream periods 3 and 20 land above and below the validity range.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    localparam int TIME_W = 32;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_A   = 2'd1,
        SRC_B   = 2'd2,
        SRC_RSV = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_FREE  = 2'd1,
        ST_TRACK = 2'd2
    } edge_st_e;

    // true when time a has reached or passed time b, across wrap
    function automatic logic t_reached(input logic [TIME_W-1:0] a,
                                       input logic [TIME_W-1:0] b);
        return $signed(a - b) >= 0;
    endfunction

    // true when time a lies strictly after time b, across wrap
    function automatic logic t_after(input logic [TIME_W-1:0] a,
                                     input logic [TIME_W-1:0] b);
        return $signed(a - b) > 0;
    endfunction

endpackage

// File: rtl/refclk_frame_tap.sv
// Derives sample events from an eight-channel word stream: one event at the
// middle of the frame and one at its end.
module refclk_frame_tap #(
    parameter int CH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic word_i,
    output logic evt_o
);
    localparam int IW = $clog2(CH + 1);

    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_inc;

    assign idx_inc = idx_q + IW'(1);
    assign evt_o   = word_i && !sync_i &&
                     ((idx_inc == IW'(CH / 2)) || (idx_inc == IW'(CH)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (sync_i) begin
            idx_q <= '0;
        end else if (word_i) begin
            idx_q <= (idx_inc == IW'(CH)) ? '0 : idx_inc;
        end
    end
endmodule

// File: rtl/refclk_valid_win.sv
// Counts events between detection ticks and grades the count against a range.
module refclk_valid_win #(
    parameter int VMIN = 3,
    parameter int VMAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic tick_i,
    output logic valid_o
);
    localparam int VW = $clog2(VMAX + 2);

    logic [VW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_o <= 1'b0;
        end else if (tick_i) begin
            valid_o <= (cnt_q >= VW'(VMIN)) && (cnt_q <= VW'(VMAX));
            cnt_q   <= evt_i ? VW'(1) : '0;
        end else if (evt_i && (cnt_q <= VW'(VMAX))) begin
            cnt_q <= cnt_q + VW'(1);
        end
    end
endmodule

// File: rtl/refclk_edge_gen.sv
module refclk_edge_gen
    import refclk_pkg::*;
#(
    parameter int INCR   = 1000,
    parameter int MARGIN = 50,
    parameter int SPT_A  = 16,
    parameter int SPT_B  = 8,
    parameter int VMIN   = 12,
    parameter int VMAX   = 20,
    parameter int CH_B   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] time_now,
    input  logic [1:0]  mode_sel,
    input  logic        a_smp,
    input  logic        b_sync,
    input  logic        b_word,
    output logic        ref_clk,
    output logic        det_tick,
    output logic [1:0]  src_valid
);
    localparam int          SPT_MAX = (SPT_A > SPT_B) ? SPT_A : SPT_B;
    localparam int          CW      = $clog2(SPT_MAX + 2);
    localparam int          NSRC    = 2;
    localparam logic [31:0] INCR_T  = 32'(INCR);
    localparam logic [31:0] HALF_T  = 32'(INCR / 2);
    localparam logic [31:0] LATE_T  = 32'(INCR + MARGIN);
    localparam logic [31:0] EARLY_T = 32'(INCR - MARGIN);

    edge_st_e       st_q, st_d;
    logic [31:0]    last_q, nxt_edge_q, nxt_det_q;
    logic [CW-1:0]  cnt_q, cnt_inc, spt_sel;
    logic           ref_q, tick_q;
    logic [NSRC-1:0] src_evt;
    logic           ext_evt, ext_ok, local_due, det_due, gate_ok;

    // per-source sample event recovery
    assign src_evt[0] = a_smp;

    refclk_frame_tap #(.CH(CH_B)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (b_sync),
        .word_i (b_word),
        .evt_o  (src_evt[1])
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_win
        refclk_valid_win #(.VMIN(VMIN), .VMAX(VMAX)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (src_evt[s]),
            .tick_i  (tick_q),
            .valid_o (src_valid[s])
        );
    end

    // source selection
    always_comb begin
        ext_evt = 1'b0;
        ext_ok  = 1'b0;
        spt_sel = CW'(SPT_A);
        unique case (src_sel_e'(mode_sel))
            SRC_A: begin
                ext_evt = src_evt[0];
                ext_ok  = src_valid[0];
                spt_sel = CW'(SPT_A);
            end
            SRC_B: begin
                ext_evt = src_evt[1];
                ext_ok  = src_valid[1];
                spt_sel = CW'(SPT_B);
            end
            SRC_INT, SRC_RSV: begin
                ext_ok  = 1'b0;
            end
        endcase
    end

    assign local_due = t_reached(time_now, nxt_edge_q);
    assign det_due   = t_reached(time_now, nxt_det_q);
    assign gate_ok   = t_after(time_now, last_q + EARLY_T);
    assign cnt_inc   = cnt_q + CW'(1);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT:  st_d = ST_FREE;
            ST_FREE:  if (ext_ok)  st_d = ST_TRACK;
            ST_TRACK: if (!ext_ok) st_d = ST_FREE;
            default:  st_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_INIT;
        else        st_q <= st_d;
    end

    // edge scheduling and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q      <= 1'b0;
            tick_q     <= 1'b0;
            last_q     <= '0;
            nxt_edge_q <= '0;
            nxt_det_q  <= '0;
            cnt_q      <= '0;
        end else begin
            unique case (st_q)
                ST_INIT: begin
                    tick_q     <= 1'b0;
                    last_q     <= time_now;
                    nxt_edge_q <= time_now + INCR_T;
                    nxt_det_q  <= time_now + HALF_T;
                    cnt_q      <= '0;
                end
                ST_FREE, ST_TRACK: begin
                    tick_q <= det_due;
                    if (det_due) nxt_det_q <= nxt_det_q + INCR_T;
                    if (local_due) begin
                        ref_q      <= ~ref_q;
                        last_q     <= nxt_edge_q;
                        nxt_edge_q <= nxt_edge_q + INCR_T;
                        nxt_det_q  <= nxt_edge_q + HALF_T;
                        cnt_q      <= '0;
                    end else if (st_q == ST_TRACK && ext_ok && ext_evt) begin
                        if (cnt_inc >= spt_sel) begin
                            if (gate_ok) begin
                                ref_q      <= ~ref_q;
                                last_q     <= time_now;
                                nxt_edge_q <= time_now + LATE_T;
                                cnt_q      <= '0;
                            end else begin
                                cnt_q <= spt_sel;
                            end
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end else if (st_q == ST_FREE) begin
                        cnt_q <= '0;
                    end
                end
                default: begin
                    tick_q <= 1'b0;
                end
            endcase
        end
    end

    assign ref_clk  = ref_q;
    assign det_tick = tick_q;

endmodule

// File: rtl/refclk_edge_gen_chk.sv
module refclk_edge_gen_chk #(
    parameter int INCR   = 1000,
    parameter int MARGIN = 50
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] time_now,
    input logic        ref_clk,
    input logic        det_tick,
    input logic [1:0]  src_valid
);
    logic        ref_d;
    logic        seen_q;
    logic [31:0] prev_t;
    logic [31:0] gap;

    assign gap = time_now - prev_t;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_d  <= 1'b0;
            seen_q <= 1'b0;
            prev_t <= '0;
        end else begin
            ref_d <= ref_clk;
            if (ref_clk != ref_d) begin
                seen_q <= 1'b1;
                prev_t <= time_now;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (ref_clk == 1'b0 && det_tick == 1'b0 && src_valid == 2'b00)
                else $error("R1: outputs not quiet in reset");
        end
    end

    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        det_tick |=> !det_tick)
        else $error("R3: detection tick longer than one cycle");

    a_r4_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_valid) |-> $past(det_tick))
        else $error("R4: validity changed without a tick");

    // spacing bounds assume the time counter advances one unit per cycle
    a_r6_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clk != ref_d && seen_q) |-> ($signed(gap) > (INCR - MARGIN)))
        else $error("R6: edges closer than INCR-MARGIN");

    a_r7_max_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clk != ref_d && seen_q) |-> ($signed(gap) <= (INCR + MARGIN)))
        else $error("R7: edges further apart than INCR+MARGIN");

endmodule

bind refclk_edge_gen refclk_edge_gen_chk #(.INCR(INCR), .MARGIN(MARGIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_now  (time_now),
    .ref_clk   (ref_clk),
    .det_tick  (det_tick),
    .src_valid (src_valid)
);

// File: tb/refclk_edge_gen_bench.sv
`timescale 1ns/1ps
module refclk_edge_gen_bench;
    localparam int INCR   = 40;
    localparam int MARGIN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tnow = 32'hFFFF_FF00;
    logic [1:0]  mode_sel = 2'd0;
    logic        a_smp = 1'b0, b_sync = 1'b0, b_word = 1'b0;
    logic        ref_clk, det_tick;
    logic [1:0]  src_valid;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int a_period = 0, a_ph = 0, b_ph = 0;
    bit b_on = 1'b0;
    logic ref_prev = 1'b0;
    logic [31:0] edge_t [0:1023];
    logic [31:0] tick_t [0:1023];
    int n_edge = 0, n_tick = 0;

    always #2.5 clk = ~clk;

    refclk_edge_gen #(.INCR(INCR), .MARGIN(MARGIN), .SPT_A(5), .SPT_B(4),
                      .VMIN(3), .VMAX(8), .CH_B(8)) u_refclk_edge_gen (
        .clk(clk), .rst_n(rst_n), .time_now(tnow), .mode_sel(mode_sel),
        .a_smp(a_smp), .b_sync(b_sync), .b_word(b_word),
        .ref_clk(ref_clk), .det_tick(det_tick), .src_valid(src_valid));

    // monitor and stream generators; tnow read here is the value seen at the last posedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_clk != ref_prev && n_edge < 1024) begin
                edge_t[n_edge] = tnow;
                n_edge++;
            end
            if (det_tick && n_tick < 1024) begin
                tick_t[n_tick] = tnow;
                n_tick++;
            end
        end
        ref_prev <= ref_clk;
        tnow     <= tnow + 32'd1;
        if (a_period != 0) begin
            if (a_ph >= a_period - 1) begin a_ph <= 0; a_smp <= 1'b1; end
            else begin a_ph <= a_ph + 1; a_smp <= 1'b0; end
        end else begin
            a_smp <= 1'b0;
        end
        if (b_on) begin
            b_ph   <= (b_ph == 17) ? 0 : b_ph + 1;
            b_sync <= (b_ph == 0);
            b_word <= (b_ph != 0) && (b_ph % 2 == 0);
        end else begin
            b_sync <= 1'b0;
            b_word <= 1'b0;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_intervals(input string tag, input int cnt, input int exp);
        for (int k = n_edge - cnt; k < n_edge; k++) begin
            logic [31:0] d;
            d = edge_t[k] - edge_t[k-1];
            check_eq(tag, int'(d), exp);
        end
    endtask

    task automatic t_reset;
        step(3);
        check_eq("R1 ref_clk in reset", int'(ref_clk), 0);
        check_eq("R1 det_tick in reset", int'(det_tick), 0);
        check_eq("R1 src_valid in reset", int'(src_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
    endtask

    // local schedule across the time-counter wrap, with idle sources
    task automatic t_local;
        logic [31:0] e, tk;
        int ne, nt;
        step(420);
        check_intervals("R2/R10 local spacing across wrap", 6, INCR);
        ne = n_edge;
        while (n_edge == ne) step(1);
        e = edge_t[n_edge-1];
        nt = n_tick;
        while (n_tick == nt) step(1);
        tk = tick_t[n_tick-1];
        check_eq("R3 tick after local edge", int'(tk - e), INCR / 2);
        nt = n_tick;
        while (n_tick == nt) step(1);
        check_eq("R3 tick cadence", int'(tick_t[n_tick-1] - tk), INCR);
        check_eq("R4 no events gives invalid", int'(src_valid), 0);
    endtask

    task automatic t_internal_ignores;
        a_period = 7;
        b_on = 1'b1;
        mode_sel = 2'd0;
        step(300);
        check_intervals("R2 internal ignores strobes", 4, INCR);
        check_eq("R4 both sources in range", int'(src_valid), 3);
        mode_sel = 2'd3;
        step(200);
        check_intervals("R2 code 3 acts internal", 2, INCR);
    endtask

    task automatic t_ext_a;
        mode_sel = 2'd1;
        step(400);
        check_intervals("R5 source A count edges", 4, 35);
    endtask

    task automatic t_gate;
        a_period = 5;
        step(400);
        check_intervals("R6 margin gate holds early edges", 4, 35);
    endtask

    task automatic t_stop;
        int start;
        bit found = 1'b0;
        start = n_edge;
        a_period = 0;
        step(300);
        for (int k = start; k < n_edge - 1; k++) begin
            if (!found && int'(edge_t[k] - edge_t[k-1]) != 35) begin
                found = 1'b1;
                check_eq("R7 first fallback edge", int'(edge_t[k] - edge_t[k-1]), INCR + MARGIN);
                check_eq("R7 local cadence resumes", int'(edge_t[k+1] - edge_t[k]), INCR);
            end
        end
        if (!found) check_eq("R7 fallback edge seen", 0, 1);
    endtask

    task automatic t_ext_b;
        mode_sel = 2'd2;
        step(450);
        check_eq("R8 source B valid", int'(src_valid[1]), 1);
        check_intervals("R8 two events per frame", 4, 36);
    endtask

    task automatic t_range;
        b_on = 1'b0;
        mode_sel = 2'd1;
        a_period = 3;
        step(300);
        check_eq("R4 above max is invalid", int'(src_valid[0]), 0);
        check_intervals("R9 invalid source keeps local timing", 3, INCR);
        a_period = 20;
        step(300);
        check_eq("R4 below min is invalid", int'(src_valid[0]), 0);
        check_intervals("R9 sparse source keeps local timing", 3, INCR);
        a_period = 7;
        step(200);
        check_eq("R4 inside range is valid", int'(src_valid[0]), 1);
    endtask

    initial begin
        t_reset();
        t_local();
        t_internal_ignores();
        t_ext_a();
        t_gate();
        t_stop();
        t_ext_b();
        t_range();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule